// File: doc/BRIEF.md
# Flow-Control Pause Frame Generator

This block lets software request a single flow-control PAUSE frame by writing one register. A write to the timer register is accepted when transmit flow control is enabled and no earlier frame is still being sent. The block stores the 16-bit quanta value and streams a complete 60-byte PAUSE frame toward the transmit MAC datapath. The stream is one byte per handshake with valid, ready and last signals. The frame check sequence and preamble are added further down the transmit path.

The frame's source address comes from three 16-bit configuration registers. When the final byte has been accepted, a sticky done flag is set. Software clears the flag by writing a one to it. The flag, gated by an interrupt enable, drives the interrupt output. A timer write that arrives while a frame is in flight has no effect at all. A timer write that arrives while flow control is disabled also has no effect.

Top module: `pause_frame_gen`

## Requirements
- R1: After reset, the timer register, control register and status register all read 0, `tx_tvalid` is low and `irq` is low.
- R2: A write to address 0 (timer) is accepted when no frame is in flight and control bit 0 (transmit flow-control enable) is 1. The value is then readable at address 0, and `tx_tvalid` is high from the next cycle on.
- R3: The first 18 bytes of the frame, in order, are: 01 80 C2 00 00 01; the source address with its most significant byte first; 88 08; 00 01; and the timer value with its high byte first.
- R4: Bytes 19 to 60 are zero. The frame is exactly 60 bytes long. `tx_tlast` is high on byte 60 and on no other byte.
- R5: While `tx_tvalid` is high and `tx_tready` is low, `tx_tvalid` and `tx_tdata` stay unchanged into the next cycle.
- R6: A timer write made while a frame is in flight, including the cycle in which the last byte is accepted, leaves the stored value unchanged and starts no further frame.
- R7: While control bit 0 is 0, a timer write stores nothing and starts no frame.
- R8: In the cycle after the last byte is accepted, status bit 0 (done) reads 1 and status bit 1 (busy) reads 0. Busy reads 1 while a frame is in flight.
- R9: Writing status (address 5) with bit 0 set clears done. Writing it with bit 0 clear leaves done unchanged. When a clear coincides with the acceptance of a last byte, done ends up set.
- R10: `irq` equals done AND control bit 1 (interrupt enable).
- R11: Addresses 1, 2 and 3 hold source-address bits 47:32, 31:16 and 15:0, and each reads back the value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| tx_tdata | output | 8 | Frame byte |
| tx_tvalid | output | 1 | Frame byte valid |
| tx_tready | input | 1 | Downstream accepts byte |
| tx_tlast | output | 1 | Final byte of the frame |
| irq | output | 1 | Interrupt, done gated by enable |

## Verification
Two functions can fall in the same cycle, and both involve the acceptance of the final byte. The first is a software clear of done in that cycle, where done must end up set. The second is a new timer write in that cycle, which must be dropped because the frame still counts as in flight. The bench holds ready high so that the final byte is accepted at a known edge. It places the register write on exactly that edge. It then judges the outcome by reading status and the timer value, and by watching for any extra frame. Random payloads, addresses and ready patterns exercise the byte layout and the back-pressure behaviour around those directed cases.

// File: rtl/pause_gen_pkg.sv
// Package: shared constants and register address map for the pause frame generator.
// Assumes: the quanta and register widths are fixed at 16 bits by the frame format.
package pause_gen_pkg;
    localparam int REG_W    = 16;
    localparam int ADDR_W   = 3;
    localparam int HDR_BYTES = 18;

    localparam logic [47:0] PAUSE_DST    = 48'h0180C2000001;
    localparam logic [15:0] CTRL_ETYPE   = 16'h8808;
    localparam logic [15:0] PAUSE_OPCODE = 16'h0001;

    typedef enum logic [ADDR_W-1:0] {
        A_TIMER  = 3'd0,
        A_SA_HI  = 3'd1,
        A_SA_MID = 3'd2,
        A_SA_LO  = 3'd3,
        A_CTRL   = 3'd4,
        A_STATUS = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/pause_regs.sv
// Module: pause_regs
// Register file of the generator: the timer value, three source-address slices,
// the control bits and the sticky done flag. It decides whether a timer write is
// accepted and raises a one-cycle start.
// Assumes: busy and frame_done come from the sequencer in the same clock domain.
module pause_regs
    import pause_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              busy,
    input  logic              frame_done,
    output logic [REG_W-1:0]  rd_data,
    output logic [REG_W-1:0]  timer_q,
    output logic [47:0]       sa_q,
    output logic              tfc_en,
    output logic              irq_en,
    output logic              done_q,
    output logic              start
);
    localparam int SA_SLICES = 3;

    logic wr_timer;
    logic wr_ctrl;
    logic wr_status;

    // Decode the write address into per-register strobes.
    always_comb begin
        wr_timer  = wr_en && (wr_addr == A_TIMER);
        wr_ctrl   = wr_en && (wr_addr == A_CTRL);
        wr_status = wr_en && (wr_addr == A_STATUS);
    end

    // A timer write is accepted only when idle and flow control is enabled.
    assign start = wr_timer && !busy && tfc_en;

    // Keep the quanta value of the last accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)     timer_q <= '0;
        else if (start) timer_q <= wr_data;
    end

    // Source-address slices, most significant slice at the lowest address.
    genvar g;
    generate
        for (g = 0; g < SA_SLICES; g++) begin : g_sa
            logic [REG_W-1:0] q;
            // Hold one 16-bit slice of the source address.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && (wr_addr == ADDR_W'(int'(A_SA_HI) + g)))
                    q <= wr_data;
            end
        end
    endgenerate

    assign sa_q = {g_sa[0].q, g_sa[1].q, g_sa[2].q};

    // Control bits: bit 0 flow-control enable, bit 1 interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tfc_en <= 1'b0;
            irq_en <= 1'b0;
        end else if (wr_ctrl) begin
            tfc_en <= wr_data[0];
            irq_en <= wr_data[1];
        end
    end

    // Sticky done flag; setting on frame completion wins over a W1C clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                       done_q <= 1'b0;
        else if (frame_done)              done_q <= 1'b1;
        else if (wr_status && wr_data[0]) done_q <= 1'b0;
    end

    // Combinational read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_TIMER:  rd_data = timer_q;
            A_SA_HI:  rd_data = g_sa[0].q;
            A_SA_MID: rd_data = g_sa[1].q;
            A_SA_LO:  rd_data = g_sa[2].q;
            A_CTRL:   rd_data = {{(REG_W-2){1'b0}}, irq_en, tfc_en};
            A_STATUS: rd_data = {{(REG_W-2){1'b0}}, busy, done_q};
            default:  rd_data = '0;
        endcase
    end

    // R6: a timer write during a frame leaves the stored value alone.
    a_r6_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_addr == A_TIMER) |=> $stable(timer_q));

    // R9: completion always leaves done set, even against a clear.
    a_r9_done_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> done_q);

    // R9: done only falls after a write of one to status bit 0.
    a_r9_done_clear_only_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_q) |-> $past(wr_en && wr_addr == A_STATUS && wr_data[0]));
endmodule

// File: rtl/pause_seq.sv
// Module: pause_seq
// Byte sequencer: walks a byte index across the frame, advancing only on a
// valid-and-ready handshake, and flags the acceptance of the final byte.
// Assumes: start is raised only while idle.
module pause_seq #(
    parameter int FRAME_LEN = 60
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         tready,
    output logic                         busy,
    output logic [$clog2(FRAME_LEN)-1:0] idx,
    output logic                         tlast,
    output logic                         frame_done
);
    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    logic hs;

    // Handshake, last-byte marker and completion pulse.
    always_comb begin
        hs         = busy && tready;
        tlast      = busy && (idx == LAST_IDX);
        frame_done = hs && tlast;
    end

    // Busy flag and byte index; busy clears as the last byte is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (hs) begin
            if (idx == LAST_IDX) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx  <= idx + 1'b1;
            end
        end
    end

    // R5: back-pressure freezes the index and keeps the frame in flight.
    a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tready) |=> (busy && $stable(idx)));

    // R2: the register file never starts a frame while one is in flight.
    a_r2_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R4: the index never runs past the final byte.
    a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx <= LAST_IDX));
endmodule

// File: rtl/pause_byte_mux.sv
// Module: pause_byte_mux
// Selects the frame byte for a given index: an 18-byte header built from the
// fixed destination, source address, type, opcode and quanta, then zero padding.
// Assumes: the index is below the frame length; indices past the header give zero.
module pause_byte_mux
    import pause_gen_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [47:0]      sa,
    input  logic [REG_W-1:0] quanta,
    output logic [7:0]       byte_o
);
    logic [HDR_BYTES*8-1:0] hdr;

    // Assemble the header, first byte in the top bits.
    assign hdr = {PAUSE_DST, sa, CTRL_ETYPE, PAUSE_OPCODE, quanta};

    // Pick the header byte matching the index, zero for the padding.
    always_comb begin
        byte_o = 8'h00;
        for (int i = 0; i < HDR_BYTES; i++) begin
            if (idx == IDX_W'(i))
                byte_o = hdr[(HDR_BYTES-1-i)*8 +: 8];
        end
    end
endmodule

// File: rtl/pause_frame_gen.sv
// Module: pause_frame_gen (top)
// Register-triggered flow-control PAUSE frame generator. It joins the register
// file, the byte sequencer and the byte selector, and gates the interrupt.
// Assumes: FRAME_LEN covers at least the 18-byte header; FCS is added downstream.
module pause_frame_gen
    import pause_gen_pkg::*;
#(
    parameter int FRAME_LEN = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic [7:0]        tx_tdata,
    output logic              tx_tvalid,
    input  logic              tx_tready,
    output logic              tx_tlast,
    output logic              irq
);
    localparam int IDX_W = $clog2(FRAME_LEN);

    logic             busy;
    logic             frame_done;
    logic             start;
    logic             tfc_en;
    logic             irq_en;
    logic             done_q;
    logic [REG_W-1:0] timer_q;
    logic [47:0]      sa_q;
    logic [IDX_W-1:0] idx;

    pause_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .busy       (busy),
        .frame_done (frame_done),
        .rd_data    (rd_data),
        .timer_q    (timer_q),
        .sa_q       (sa_q),
        .tfc_en     (tfc_en),
        .irq_en     (irq_en),
        .done_q     (done_q),
        .start      (start)
    );

    pause_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .tready     (tx_tready),
        .busy       (busy),
        .idx        (idx),
        .tlast      (tx_tlast),
        .frame_done (frame_done)
    );

    pause_byte_mux #(.IDX_W(IDX_W)) u_mux (
        .idx    (idx),
        .sa     (sa_q),
        .quanta (timer_q),
        .byte_o (tx_tdata)
    );

    // Stream valid while a frame is in flight; interrupt is done gated by enable.
    assign tx_tvalid = busy;
    assign irq       = done_q && irq_en;

    // R7: with flow control off, an idle timer write leaves the stream idle.
    a_r7_disabled_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_TIMER && !tx_tvalid && !tfc_en) |=> !tx_tvalid);

    // R2: an accepted timer write puts a frame on the stream next cycle.
    a_r2_write_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_TIMER && !tx_tvalid && tfc_en) |=> tx_tvalid);

    // R8: the stream drops valid right after the last byte is taken.
    a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_tvalid && tx_tready && tx_tlast) |=> !tx_tvalid);

    // R5: a stalled byte is presented unchanged next cycle.
    a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_tvalid && !tx_tready) |=> (tx_tvalid && $stable(tx_tdata)));
endmodule

// File: tb/test_pause_frame_gen.sv
// Bench for pause_frame_gen: seeded random payloads and ready patterns, plus
// directed collisions on the last-byte edge. A monitor scores every byte.
module test_pause_frame_gen;
    localparam int FL = 60;
    localparam logic [2:0] AT = 3'd0, AH = 3'd1, AM = 3'd2, AL = 3'd3, AC = 3'd4, AS = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  tdata;
    logic        tvalid;
    logic        tready = 1'b0;
    logic        tlast;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int frames = 0;
    int mon_idx = 0;
    bit rand_ready = 1'b0;
    bit held_v = 1'b0;
    logic [7:0]  held_d = '0;
    logic [47:0] exp_sa = '0;
    logic [15:0] exp_tmr = '0;

    always #10 clk = ~clk;

    pause_frame_gen i_pause_frame_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_tdata(tdata), .tx_tvalid(tvalid), .tx_tready(tready),
        .tx_tlast(tlast), .irq(irq)
    );

    function automatic logic [7:0] exp_byte(int i, logic [47:0] sa, logic [15:0] t);
        logic [143:0] h;
        h = {8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01, sa, 8'h88, 8'h08, 8'h00, 8'h01, t};
        if (i < 18) return h[(17-i)*8 +: 8];
        return 8'h00;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // Drive ready and score every accepted byte against the model frame.
    always @(negedge clk) begin
        if (rst_n) begin
            tready = rand_ready ? 1'($urandom % 2) : 1'b1;
            if (held_v)
                check(tvalid && tdata == held_d, "R5", "stalled byte changed", {tvalid, tdata}, {1'b1, held_d});
            held_v = tvalid && !tready;
            held_d = tdata;
            if (tvalid && tready) begin
                check(tdata == exp_byte(mon_idx, exp_sa, exp_tmr), (mon_idx < 18) ? "R3" : "R4",
                      $sformatf("byte %0d", mon_idx + 1), tdata, exp_byte(mon_idx, exp_sa, exp_tmr));
                check(tlast == (mon_idx == FL - 1), "R4", $sformatf("tlast at byte %0d", mon_idx + 1),
                      tlast, (mon_idx == FL - 1));
                if (mon_idx == FL - 1) begin
                    mon_idx = 0;
                    frames++;
                end else begin
                    mon_idx++;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] t;
        int base;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        rd(AT, v); check(v == 16'h0, "R1", "timer", v, 0);
        rd(AC, v); check(v == 16'h0, "R1", "ctrl", v, 0);
        rd(AS, v); check(v == 16'h0, "R1", "status", v, 0);
        check(!tvalid && !irq, "R1", "tvalid/irq", {tvalid, irq}, 0);

        // R11: source-address slices.
        exp_sa = 48'h02_11_22_33_44_55;
        wr(AH, exp_sa[47:32]); wr(AM, exp_sa[31:16]); wr(AL, exp_sa[15:0]);
        rd(AH, v); check(v == exp_sa[47:32], "R11", "sa hi", v, exp_sa[47:32]);
        rd(AM, v); check(v == exp_sa[31:16], "R11", "sa mid", v, exp_sa[31:16]);
        rd(AL, v); check(v == exp_sa[15:0], "R11", "sa lo", v, exp_sa[15:0]);

        // R7: flow control off, timer write has no effect.
        wr(AC, 16'h0000);
        wr(AT, 16'h1111);
        repeat (70) @(negedge clk);
        check(frames == 0, "R7", "frames while disabled", frames, 0);
        rd(AT, v); check(v == 16'h0, "R7", "timer while disabled", v, 0);

        wr(AC, 16'h0003);
        for (int k = 0; k < 6; k++) begin
            rand_ready = (k % 2) == 1;
            exp_sa = {16'($urandom), 32'($urandom)};
            wr(AH, exp_sa[47:32]); wr(AM, exp_sa[31:16]); wr(AL, exp_sa[15:0]);
            t = 16'($urandom);
            exp_tmr = t;
            wr(AT, t);
            check(tvalid == 1'b1, "R2", "tvalid after write", tvalid, 1);
            rd(AT, v); check(v == t, "R2", "timer readback", v, t);
            rd(AS, v); check(v[1] == 1'b1, "R8", "busy in flight", v[1], 1);
            if (k >= 2) begin
                repeat (3) @(negedge clk);
                wr(AT, ~t);
                rd(AT, v); check(v == t, "R6", "timer after busy write", v, t);
            end
            wait (frames == k + 1);
            @(negedge clk);
            rd(AS, v); check(v == 16'h0001, "R8", "status after frame", v, 1);
            check(irq == 1'b1, "R10", "irq with enable", irq, 1);
            wr(AS, 16'h0000);
            rd(AS, v); check(v == 16'h0001, "R9", "write zero keeps done", v, 1);
            wr(AS, 16'h0001);
            rd(AS, v); check(v == 16'h0000, "R9", "w1c clears done", v, 0);
            check(irq == 1'b0, "R10", "irq after clear", irq, 0);
            repeat (5) @(negedge clk);
            check(frames == k + 1 && !tvalid, "R6", "no queued frame", frames, k + 1);
        end

        // R9: clear lands on the last-byte edge; set wins.
        rand_ready = 1'b0;
        base = frames;
        exp_tmr = 16'hABCD;
        wr(AT, exp_tmr);
        repeat (58) @(negedge clk);
        wr(AS, 16'h0001);
        check(frames == base + 1, "R9", "frame done at collision", frames, base + 1);
        rd(AS, v); check(v == 16'h0001, "R9", "done after colliding clear", v, 1);
        wr(AS, 16'h0001);

        // R6 and R10: timer write on the last-byte edge with interrupt disabled.
        wr(AC, 16'h0001);
        base = frames;
        exp_tmr = 16'h0F0F;
        wr(AT, exp_tmr);
        repeat (58) @(negedge clk);
        wr(AT, 16'h7777);
        rd(AT, v); check(v == 16'h0F0F, "R6", "timer after last-edge write", v, 16'h0F0F);
        rd(AS, v); check(v == 16'h0001, "R8", "status after frame", v, 1);
        check(irq == 1'b0, "R10", "irq with enable off", irq, 0);
        repeat (70) @(negedge clk);
        check(frames == base + 1 && !tvalid, "R6", "no frame from last-edge write", frames, base + 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule